// File: doc/BRIEF.md
# Strobed FIFO with Ready Flags

This block is a first-in first-out buffer holding 64 words of 5 bits. A word is written when the shift-in strobe rises and read when the shift-out strobe rises. The two strobes are edge-detected on the system clock and are independent of each other. Status is given as two handshake flags instead of full and empty. The input-ready flag says a word can be taken. The output-ready flag says a valid word sits on the data outputs. Because of these flags, one instance's output-ready can drive the next instance's shift-in for more depth, and instances sharing strobes can sit side by side for more width.

A master reset empties the buffer. An output-enable input models a three-state bus as a data vector plus a drive-enable: while disabled, the drive-enable is low and the data vector reads zero.

The control is a three-state machine: EMPTY, PARTIAL and FULL.
- Fill-first (EMPTY→PARTIAL) happens on an accepted write.
- Top-off (PARTIAL→FULL) happens on a write alone at 63 words.
- Drain-last (PARTIAL→EMPTY) happens on a read alone at one word.
- Unload (FULL→PARTIAL) happens on a read alone.
- Every other case holds the state, including the swap of a simultaneous write and read in FULL.

Top module: `strobed_fifo`

## Requirements
- R1: While and after master reset (active high), out_rdy is 0, in_rdy is 1, dout is 0, and no word is held.
- R2: A shift-in rising edge seen at a clock edge while in_rdy is 1 stores din; on an empty buffer out_rdy is 1 and the word is on dout after that clock edge.
- R3: in_rdy is 0 exactly when 64 words are held; a shift-in edge then, without an accepted shift-out edge in the same cycle, is ignored.
- R4: A shift-out edge while out_rdy is 0 is ignored and leaves the buffer empty.
- R5: Words leave in the order they entered; each accepted shift-out edge advances dout to the next word.
- R6: A strobe held high for many cycles moves exactly one word; only its 0-to-1 change acts.
- R7: On a full buffer, a shift-in edge and a shift-out edge in the same cycle both complete: the head word leaves, din is stored, and in_rdy stays 0.
- R8: While oe is 0, dout_en is 0 and dout is 0; oe has no effect on stored data or flags.
- R9: While out_rdy is 0, dout is 0.
- R10: Shift-in and shift-out edges in the same cycle on an empty buffer store the word and read nothing.
- R11: Strobes toggling every cycle in burst, with flags ignored, lose and duplicate no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mr | input | 1 | Master reset, active high, asynchronous assert |
| si | input | 1 | Shift-in strobe, acts on rising edge |
| so | input | 1 | Shift-out strobe, acts on rising edge |
| din | input | 5 | Word to write |
| oe | input | 1 | Output enable |
| dout | output | 5 | Head word (zero when not driven or not valid) |
| dout_en | output | 1 | Drive-enable of the modelled three-state bus |
| in_rdy | output | 1 | Input-ready flag |
| out_rdy | output | 1 | Output-ready flag |

## Verification
A write and a read can fall in the same cycle, and what happens depends on the fill level. On a full buffer both must complete. On an empty buffer only the write may take effect. Directed sequences fill the buffer to 64 words and then raise both strobes together; they also raise both strobes together on an empty buffer. A long random run toggles both strobes freely. In every case the flags and head word are compared against a bench-side queue model that applies the acceptance rules of R3, R4, R7 and R10.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
    typedef enum logic [1:0] {
        FS_EMPTY   = 2'd0,
        FS_PARTIAL = 2'd1,
        FS_FULL    = 2'd2
    } fill_state_e;
endpackage

// File: rtl/sfifo_edge.sv
module sfifo_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         mr,
    input  logic [N-1:0] strb,
    output logic [N-1:0] fire
);
    for (genvar g = 0; g < N; g++) begin : g_lane
        logic prev_q;
        always_ff @(posedge clk or posedge mr) begin
            if (mr) prev_q <= 1'b0;
            else    prev_q <= strb[g];
        end
        assign fire[g] = strb[g] & ~prev_q;
    end
endmodule

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl
    import sfifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int PTR_W = 6,
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             mr,
    input  logic             push_req,
    input  logic             pop_req,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_ptr,
    output logic [PTR_W-1:0] rd_ptr,
    output logic             in_rdy,
    output logic             out_rdy,
    output logic [LVL_W-1:0] level
);
    localparam logic [PTR_W-1:0] LAST_IDX  = PTR_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] ONE_SHORT = LVL_W'(DEPTH - 1);
    localparam logic [LVL_W-1:0] ONE_WORD  = LVL_W'(1);

    fill_state_e      state_q, state_d;
    logic             pop_ok, push_ok;
    logic [PTR_W-1:0] wr_q, rd_q;
    logic [LVL_W-1:0] lvl_q;

    always_comb begin
        pop_ok  = pop_req & (state_q != FS_EMPTY);
        push_ok = push_req & ((state_q != FS_FULL) | pop_ok);
    end

    always_ff @(posedge clk or posedge mr) begin
        if (mr) state_q <= FS_EMPTY;
        else    state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FS_EMPTY: begin
                if (push_ok) state_d = FS_PARTIAL;
            end
            FS_PARTIAL: begin
                if (push_ok && !pop_ok && lvl_q == ONE_SHORT)
                    state_d = FS_FULL;
                else if (pop_ok && !push_ok && lvl_q == ONE_WORD)
                    state_d = FS_EMPTY;
            end
            FS_FULL: begin
                if (pop_ok && !push_ok) state_d = FS_PARTIAL;
            end
            default: state_d = FS_EMPTY;
        endcase
    end

    always_ff @(posedge clk or posedge mr) begin
        if (mr) begin
            wr_q  <= '0;
            rd_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (push_ok) wr_q <= (wr_q == LAST_IDX) ? '0 : wr_q + 1'b1;
            if (pop_ok)  rd_q <= (rd_q == LAST_IDX) ? '0 : rd_q + 1'b1;
            if (push_ok && !pop_ok)      lvl_q <= lvl_q + 1'b1;
            else if (pop_ok && !push_ok) lvl_q <= lvl_q - 1'b1;
        end
    end

    always_comb begin
        in_rdy  = (state_q != FS_FULL);
        out_rdy = (state_q != FS_EMPTY);
        wr_en   = push_ok;
        wr_ptr  = wr_q;
        rd_ptr  = rd_q;
        level   = lvl_q;
    end
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
    parameter int WIDTH = 5,
    parameter int DEPTH = 64,
    parameter int PTR_W = 6
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_ptr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [PTR_W-1:0] rd_ptr,
    output logic [WIDTH-1:0] rd_data
);
    logic [WIDTH-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) cells[wr_ptr] <= wr_data;
    end

    assign rd_data = cells[rd_ptr];
endmodule

// File: rtl/sfifo_drive.sv
module sfifo_drive #(
    parameter int WIDTH = 5
) (
    input  logic             oe,
    input  logic             valid,
    input  logic [WIDTH-1:0] word,
    output logic [WIDTH-1:0] bus,
    output logic             bus_en
);
    always_comb begin
        bus_en = oe;
        bus    = (oe && valid) ? word : '0;
    end
endmodule

// File: rtl/strobed_fifo.sv
module strobed_fifo #(
    parameter int WIDTH = 5,
    parameter int DEPTH = 64
) (
    input  logic             clk,
    input  logic             mr,
    input  logic             si,
    input  logic             so,
    input  logic [WIDTH-1:0] din,
    input  logic             oe,
    output logic [WIDTH-1:0] dout,
    output logic             dout_en,
    output logic             in_rdy,
    output logic             out_rdy
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int LVL_W = $clog2(DEPTH + 1);

    logic [1:0]       fire;
    logic             si_fire, so_fire;
    logic             wr_en;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [LVL_W-1:0] level;
    logic [WIDTH-1:0] head;

    sfifo_edge #(.N(2)) u_edge (
        .clk  (clk),
        .mr   (mr),
        .strb ({so, si}),
        .fire (fire)
    );
    assign si_fire = fire[0];
    assign so_fire = fire[1];

    sfifo_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .LVL_W(LVL_W)) u_ctrl (
        .clk      (clk),
        .mr       (mr),
        .push_req (si_fire),
        .pop_req  (so_fire),
        .wr_en    (wr_en),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .in_rdy   (in_rdy),
        .out_rdy  (out_rdy),
        .level    (level)
    );

    sfifo_store #(.WIDTH(WIDTH), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_data (din),
        .rd_ptr  (rd_ptr),
        .rd_data (head)
    );

    sfifo_drive #(.WIDTH(WIDTH)) u_drive (
        .oe     (oe),
        .valid  (out_rdy),
        .word   (head),
        .bus    (dout),
        .bus_en (dout_en)
    );
endmodule

// File: rtl/sfifo_checker.sv
module sfifo_checker #(
    parameter int WIDTH = 5,
    parameter int DEPTH = 64,
    parameter int LVL_W = 7
) (
    input logic             clk,
    input logic             mr,
    input logic             si_fire,
    input logic             so_fire,
    input logic             in_rdy,
    input logic             out_rdy,
    input logic             oe,
    input logic [WIDTH-1:0] dout,
    input logic             dout_en,
    input logic [LVL_W-1:0] level
);
    // R3: the two flags are never low together
    p_flags_sane_r3: assert property (@(posedge clk) disable iff (mr)
        (in_rdy || out_rdy));

    // R2: a lone accepted write raises the fill level by one
    p_write_counts_r2: assert property (@(posedge clk) disable iff (mr)
        (si_fire && in_rdy && !(so_fire && out_rdy)) |=> (level == $past(level) + 1'b1));

    // R3: a write on a full buffer with no read leaves the level alone
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (mr)
        (!in_rdy && !so_fire) |=> (level == $past(level)));

    // R4: without a write, an empty buffer stays empty
    p_no_underflow_r4: assert property (@(posedge clk) disable iff (mr)
        (!out_rdy && !si_fire) |=> !out_rdy);

    // R7: swap on a full buffer keeps it full
    p_full_swap_r7: assert property (@(posedge clk) disable iff (mr)
        (!in_rdy && si_fire && so_fire) |=> !in_rdy);

    // R8: output disabled means no drive and zero data
    p_oe_gate_r8: assert property (@(posedge clk) disable iff (mr)
        !oe |-> (!dout_en && dout == '0));

    // R9: no valid word means zero data
    p_empty_quiet_r9: assert property (@(posedge clk) disable iff (mr)
        !out_rdy |-> (dout == '0));
endmodule

bind strobed_fifo sfifo_checker #(.WIDTH(WIDTH), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
    .clk     (clk),
    .mr      (mr),
    .si_fire (si_fire),
    .so_fire (so_fire),
    .in_rdy  (in_rdy),
    .out_rdy (out_rdy),
    .oe      (oe),
    .dout    (dout),
    .dout_en (dout_en),
    .level   (level)
);

// File: tb/tb_strobed_fifo.sv
module tb_strobed_fifo;
    localparam int CLK_PERIOD = 10;
    localparam int W = 5;
    localparam int D = 64;

    logic         clk = 1'b0;
    logic         mr = 1'b1;
    logic         si = 1'b0, so = 1'b0, oe = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic         dout_en, in_rdy, out_rdy;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [W-1:0] mq [D];
    int mh = 0, mt = 0, mc = 0;
    logic psi = 1'b0, pso = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strobed_fifo dut (
        .clk(clk), .mr(mr), .si(si), .so(so), .din(din), .oe(oe),
        .dout(dout), .dout_en(dout_en), .in_rdy(in_rdy), .out_rdy(out_rdy)
    );

    function automatic logic [W-1:0] exp_dout();
        return (oe && mc > 0) ? mq[mh] : '0;
    endfunction

    task automatic check(string tag);
        logic [W-1:0] ed;
        logic er_in, er_out;
        ed = exp_dout();
        er_in = (mc < D);
        er_out = (mc > 0);
        checks++;
        if (dout !== ed || dout_en !== oe || in_rdy !== er_in || out_rdy !== er_out) begin
            fails++;
            $display("FAIL %s: dout=%h en=%b in_rdy=%b out_rdy=%b expected dout=%h en=%b in_rdy=%b out_rdy=%b",
                     tag, dout, dout_en, in_rdy, out_rdy, ed, oe, er_in, er_out);
        end
    endtask

    // called at a negedge: drive, run one clock edge, update model, check
    task automatic cyc(logic s_in, logic s_out, logic [W-1:0] d, logic o, string tag);
        logic fin, fout;
        si = s_in; so = s_out; din = d; oe = o;
        fin  = s_in & ~psi;
        fout = s_out & ~pso;
        @(posedge clk);
        @(negedge clk);
        fout = fout && (mc > 0);
        fin  = fin && ((mc < D) || fout);
        if (fout) begin mh = (mh + 1) % D; mc--; end
        if (fin)  begin mq[mt] = d; mt = (mt + 1) % D; mc++; end
        psi = s_in; pso = s_out;
        check(tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        mr = 1'b1; si = 1'b0; so = 1'b0;
        @(negedge clk);
        @(negedge clk);
        mr = 1'b0;
        mh = 0; mt = 0; mc = 0; psi = 1'b0; pso = 1'b0;
        check("R1 reset state");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual=expired expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd24681));
        repeat (3) @(negedge clk);
        do_reset();

        // R2: first write into empty buffer
        cyc(1, 0, 5'h13, 1, "R2 first write");
        cyc(0, 0, 5'h00, 1, "R2 idle");
        // R4: read then read again on empty
        cyc(0, 1, 5'h00, 1, "R5 read one");
        cyc(0, 0, 5'h00, 1, "R4 idle");
        cyc(0, 1, 5'h00, 1, "R4 read on empty ignored");
        cyc(0, 0, 5'h00, 1, "R4 idle");

        // R6: held strobe writes once
        cyc(1, 0, 5'h0a, 1, "R6 strobe rise");
        for (int k = 0; k < 5; k++) cyc(1, 0, 5'h1f, 1, "R6 strobe held");
        cyc(0, 1, 5'h00, 1, "R6 single read empties");
        for (int k = 0; k < 4; k++) cyc(0, 1, 5'h00, 1, "R6 read held");
        cyc(0, 0, 5'h00, 1, "R6 idle");

        // R10: both strobes on empty
        cyc(1, 1, 5'h15, 1, "R10 both on empty");
        cyc(0, 0, 5'h00, 1, "R10 idle");
        cyc(0, 1, 5'h00, 1, "R10 drain");
        cyc(0, 0, 5'h00, 1, "R10 idle");

        // R3: fill to full
        for (int k = 0; k < D; k++) begin
            cyc(1, 0, W'(k * 7 + 3), 1, "R3 fill");
            cyc(0, 0, 5'h00, 1, "R3 fill gap");
        end
        cyc(1, 0, 5'h1e, 1, "R3 write on full ignored");
        cyc(0, 0, 5'h00, 1, "R3 idle");

        // R7: swap on full
        cyc(1, 1, 5'h11, 1, "R7 swap on full");
        cyc(0, 0, 5'h00, 1, "R7 idle");
        cyc(1, 1, 5'h12, 1, "R7 second swap");
        cyc(0, 0, 5'h00, 1, "R7 idle");

        // R8: output disable does not disturb storage
        cyc(0, 0, 5'h00, 0, "R8 oe low");
        cyc(0, 1, 5'h00, 0, "R8 read while disabled");
        cyc(0, 0, 5'h00, 0, "R8 oe low idle");
        cyc(0, 0, 5'h00, 1, "R8 oe back");

        // R5: drain in order
        while (mc > 0) begin
            cyc(0, 1, 5'h00, 1, "R5 drain order");
            cyc(0, 0, 5'h00, 1, "R5 drain gap");
        end
        cyc(0, 1, 5'h00, 1, "R9 empty output zero");

        // R11: burst, both strobes toggling every cycle
        for (int k = 0; k < 40; k++)
            cyc(logic'(k % 2 == 0), logic'(k >= 10 && k % 2 == 1), W'(k), 1, "R11 burst");
        for (int k = 0; k < 20; k++)
            cyc(0, logic'(k % 2 == 0), 5'h00, 1, "R11 burst drain");

        // random mix
        for (int k = 0; k < 4000; k++)
            cyc(logic'($urandom_range(0, 1)), logic'($urandom_range(0, 2) == 0),
                W'($urandom), logic'($urandom_range(0, 7) != 0), "R5 random mix");

        // R1: reset mid-stream
        do_reset();
        cyc(0, 1, 5'h00, 1, "R1 empty after reset");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule